// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an internal request port to an asynchronous external SRAM-style bus. The bus has an 8-bit shared line set and a separate 8-bit high-address line set. On the shared lines the low address byte comes first. An address-latch strobe marks that phase so that an external latch can capture it. The same lines then carry the data byte. Every strobe is derived from the internal clock, and the bus carries no clock of its own.

The address space is divided into a lower and an upper sector by a 3-bit boundary that is compared against the top three address bits. Each sector has its own 2-bit wait-state code, which stretches the strobe. One code also adds an extra address-hold cycle. The requester sees a stall flag for the whole transfer and gets a one-cycle completion pulse, which for reads carries the sampled byte. The controller also drives an output-enable for the shared lines. A keeper model reports the level the lines hold while they are not driven.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ad_oe` is 0, `req_stall` is 0 and `rsp_done` is 0.
- R2: A request is accepted when `req_valid` is 1 at a rising edge while `req_stall` is 0. In the next cycle `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_out`=`req_addr[7:0]` and `bus_addr_hi`=`req_addr[15:8]`, and `bus_addr_hi` then holds that value until the next acceptance.
- R3: `bus_rd_n` and `bus_wr_n` are never low in the same cycle. A read lowers only `bus_rd_n` and a write lowers only `bus_wr_n`.
- R4: The strobe stays low for a fixed number of consecutive cycles set by the selected wait code: code 00 gives 2, 01 gives 3, 10 gives 4 and 11 gives 3.
- R5: With wait code 11 the address phase lasts two cycles. `bus_ale` is 1 only in the first of them, and `bus_ad_out` shows the low address with `bus_ad_oe`=1 in both. With any other code the address phase is a single cycle. The strobe falls in the cycle right after the address phase.
- R6: When `req_addr[15:13]` is less than `cfg_boundary`, the transfer uses `cfg_wait_lower`. Otherwise it uses `cfg_wait_upper`, so a boundary of 0 sends every address to the upper setting.
- R7: `rsp_done` is 1 for exactly one cycle, the cycle after the strobe rises. For a read, `rsp_rdata` in that cycle equals `bus_ad_in` as it stood in the last strobe-low cycle.
- R8: On a write, `bus_ad_oe` stays 1 from the address phase through the cycle after `bus_wr_n` rises. `bus_ad_out` equals the write byte in every strobe cycle and in that trailing cycle.
- R9: On a read, `bus_ad_oe` is 0 from the first strobe cycle through the completion cycle.
- R10: `req_stall` is 1 from the cycle after acceptance through the completion cycle and 0 in the cycle after that. A `req_valid` seen while `req_stall` is 1 starts nothing.
- R11: `bus_keep_on` equals `cfg_keep_en` AND NOT `bus_ad_oe`. `bus_ad_level` equals `bus_ad_out` while `bus_ad_oe` is 1. Otherwise it equals the last byte driven with `bus_ad_oe`=1, or 0 if none has been driven since reset.
- R12: The sector choice and the wait code are taken at acceptance. Changing `cfg_*` during a transfer does not alter that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_stall | output | 1 | Transfer in progress; requester must wait |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_done` on reads |
| cfg_boundary | input | 3 | Sector boundary on address bits 15:13 |
| cfg_wait_lower | input | 2 | Wait code for the lower sector |
| cfg_wait_upper | input | 2 | Wait code for the upper sector |
| cfg_keep_en | input | 1 | Keeper enable |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr_hi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 8 | Shared lines, value read from the bus |
| bus_ad_level | output | 8 | Level on the shared lines, including the held value |
| bus_keep_on | output | 1 | Keeper is holding the shared lines |

## Verification
The properties assume that `req_valid` is a level the requester drives and may hold across a transfer, and that configuration inputs can change at any time. They do not assume anything about `bus_ad_in`. The stimulus sets requests and configuration only on falling clock edges and changes `bus_ad_in` every cycle with a shift-register pattern, so that the sampled read byte is uniquely tied to one cycle. It covers single requests in both sectors under every wait code, several boundary values, a `req_valid` held through busy periods, and configuration rewritten in the middle of a transfer.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int WAIT_W = 2;
    localparam int CNT_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AHOLD,
        ST_STRB,
        ST_LAST,
        ST_END
    } xb_state_e;

    // Per-transfer timing picked at acceptance
    typedef struct packed {
        logic             extra_addr;
        logic [CNT_W-1:0] extra_strb;
    } xb_timing_t;

    // Phase flags produced by the sequencer
    typedef struct packed {
        logic ale;
        logic addr_phase;
        logic strobe;
        logic sample;
        logic done;
        logic busy;
    } xb_ctl_t;

    function automatic xb_timing_t decode_wait(input logic [WAIT_W-1:0] code);
        xb_timing_t t;
        t.extra_addr = (code == 2'b11);
        case (code)
            2'b00:   t.extra_strb = 2'd0;
            2'b01:   t.extra_strb = 2'd1;
            2'b10:   t.extra_strb = 2'd2;
            default: t.extra_strb = 2'd1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel
    import xbus_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int BND_W = 3
) (
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [BND_W-1:0]  boundary,
    input  logic [WAIT_W-1:0] wait_lower,
    input  logic [WAIT_W-1:0] wait_upper,
    output xb_timing_t        timing
);

    logic [BND_W-1:0]  top_bits;
    logic              in_lower;
    logic [WAIT_W-1:0] code;

    always_comb begin
        top_bits = addr_hi[HI_W-1 -: BND_W];
        in_lower = (top_bits < boundary);
        code     = in_lower ? wait_lower : wait_upper;
        timing   = decode_wait(code);
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  xb_timing_t timing,
    output xb_ctl_t    ctl
);

    xb_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             hold_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            hold_addr <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_ADDR;
                        cnt       <= timing.extra_strb;
                        hold_addr <= timing.extra_addr;
                    end
                end
                ST_ADDR:  state <= hold_addr ? ST_AHOLD : ST_STRB;
                ST_AHOLD: state <= ST_STRB;
                ST_STRB: begin
                    if (cnt == '0) state <= ST_LAST;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_LAST:  state <= ST_END;
                ST_END:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.ale        = (state == ST_ADDR);
        ctl.addr_phase = (state == ST_ADDR) || (state == ST_AHOLD);
        ctl.strobe     = (state == ST_STRB) || (state == ST_LAST);
        ctl.sample     = (state == ST_LAST);
        ctl.done       = (state == ST_END);
        ctl.busy       = (state != ST_IDLE);
    end

endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drive_en,
    input  logic [W-1:0] drive_val,
    input  logic         keep_en,
    output logic [W-1:0] level,
    output logic         keep_on
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)           held_q <= '0;
        else if (drive_en) held_q <= drive_val;
    end

    always_comb begin
        level   = drive_en ? drive_val : held_q;
        keep_on = keep_en && !drive_en;
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int BND_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HI_W+LO_W-1:0] req_addr,
    input  logic [LO_W-1:0]      req_wdata,
    output logic                 req_stall,
    output logic                 rsp_done,
    output logic [LO_W-1:0]      rsp_rdata,
    input  logic [BND_W-1:0]     cfg_boundary,
    input  logic [WAIT_W-1:0]    cfg_wait_lower,
    input  logic [WAIT_W-1:0]    cfg_wait_upper,
    input  logic                 cfg_keep_en,
    output logic                 bus_ale,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic [HI_W-1:0]      bus_addr_hi,
    output logic [LO_W-1:0]      bus_ad_out,
    output logic                 bus_ad_oe,
    input  logic [LO_W-1:0]      bus_ad_in,
    output logic [LO_W-1:0]      bus_ad_level,
    output logic                 bus_keep_on
);

    localparam int ADDR_W = HI_W + LO_W;

    xb_timing_t      timing;
    xb_ctl_t         ctl;
    logic            start;
    logic            wr_q;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] wd_q;
    logic [LO_W-1:0] rd_q;

    assign start = req_valid && !ctl.busy;

    xbus_sector_sel #(
        .HI_W  (HI_W),
        .BND_W (BND_W)
    ) u_sel (
        .addr_hi    (req_addr[ADDR_W-1:LO_W]),
        .boundary   (cfg_boundary),
        .wait_lower (cfg_wait_lower),
        .wait_upper (cfg_wait_upper),
        .timing     (timing)
    );

    xbus_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .timing (timing),
        .ctl    (ctl)
    );

    // Request capture at acceptance; read byte capture on the last strobe cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            lo_q <= '0;
            hi_q <= '0;
            wd_q <= '0;
            rd_q <= '0;
        end else begin
            if (start) begin
                wr_q <= req_write;
                lo_q <= req_addr[LO_W-1:0];
                hi_q <= req_addr[ADDR_W-1:LO_W];
                wd_q <= req_wdata;
            end
            if (ctl.sample && !wr_q) rd_q <= bus_ad_in;
        end
    end

    always_comb begin
        req_stall   = ctl.busy;
        rsp_done    = ctl.done;
        rsp_rdata   = rd_q;
        bus_ale     = ctl.ale;
        bus_rd_n    = !(ctl.strobe && !wr_q);
        bus_wr_n    = !(ctl.strobe && wr_q);
        bus_addr_hi = hi_q;
        bus_ad_out  = ctl.addr_phase ? lo_q : wd_q;
        bus_ad_oe   = ctl.addr_phase || (wr_q && (ctl.strobe || ctl.done));
    end

    xbus_keeper #(
        .W (LO_W)
    ) u_keep (
        .clk       (clk),
        .rst       (rst),
        .drive_en  (bus_ad_oe),
        .drive_val (bus_ad_out),
        .keep_en   (cfg_keep_en),
        .level     (bus_ad_level),
        .keep_on   (bus_keep_on)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_stall,
    input logic rsp_done,
    input logic bus_ale,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_ad_oe,
    input logic bus_keep_on
);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stall) |=> (bus_ale && bus_ad_oe && req_stall));

    assert_ale_single_R5: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);

    assert_read_release_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_ad_oe);

    assert_write_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_ad_oe);

    assert_write_tail_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> bus_ad_oe);

    assert_done_end_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> rsp_done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !req_stall);

    assert_strobe_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wr_n) |-> req_stall);

    assert_keep_off_R11: assert property (@(posedge clk) disable iff (rst)
        bus_keep_on |-> !bus_ad_oe);

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_stall   (req_stall),
    .rsp_done    (rsp_done),
    .bus_ale     (bus_ale),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_ad_oe   (bus_ad_oe),
    .bus_keep_on (bus_keep_on)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_stall;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [2:0]  cfg_boundary = 3'd4;
    logic [1:0]  cfg_wait_lower = 2'b00;
    logic [1:0]  cfg_wait_upper = 2'b00;
    logic        cfg_keep_en = 1'b1;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, bus_keep_on;
    logic [7:0]  bus_addr_hi, bus_ad_out, bus_ad_level;
    logic [7:0]  bus_ad_in = 8'h5A;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_stall(req_stall), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_boundary(cfg_boundary), .cfg_wait_lower(cfg_wait_lower),
        .cfg_wait_upper(cfg_wait_upper), .cfg_keep_en(cfg_keep_en),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_ad_level(bus_ad_level), .bus_keep_on(bus_keep_on)
    );

    // ---------------- reference model ----------------
    typedef struct {
        bit       ale, rd_n, wr_n, oe, stall, done, last, wr;
        bit [7:0] ad;
    } ent_t;

    ent_t     q[$];
    ent_t     cur;
    bit [7:0] exp_hi   = '0;
    bit [7:0] exp_keep = '0;
    bit [7:0] exp_rd   = '0;

    function automatic ent_t idle_ent();
        ent_t e;
        e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.stall = 0;
        e.done = 0; e.last = 0; e.wr = 0; e.ad = '0;
        return e;
    endfunction

    initial cur = idle_ent();

    always @(posedge clk) begin
        ent_t     e;
        bit [1:0] code;
        int       nstrb;
        if (rst) begin
            q.delete();
            cur      = idle_ent();
            exp_hi   = '0;
            exp_keep = '0;
            exp_rd   = '0;
        end else begin
            if (cur.oe) exp_keep = cur.ad;
            if (cur.last && !cur.wr) exp_rd = bus_ad_in;
            if (q.size() == 0 && !cur.stall && req_valid) begin
                // R6: sector from address bits 15:13 against the boundary
                code  = (req_addr[15:13] < cfg_boundary) ? cfg_wait_lower : cfg_wait_upper;
                nstrb = (code == 2'b00) ? 2 : (code == 2'b10) ? 4 : 3;
                exp_hi = req_addr[15:8];
                e = idle_ent();
                e.stall = 1; e.wr = req_write;
                e.ale = 1; e.oe = 1; e.ad = req_addr[7:0];
                q.push_back(e);
                if (code == 2'b11) begin
                    e.ale = 0;
                    q.push_back(e);
                end
                e.ale = 0;
                for (int i = 0; i < nstrb; i++) begin
                    e.rd_n = req_write;
                    e.wr_n = !req_write;
                    e.oe   = req_write;
                    e.ad   = req_write ? req_wdata : 8'h00;
                    e.last = (i == nstrb - 1);
                    q.push_back(e);
                end
                e.rd_n = 1; e.wr_n = 1; e.last = 0; e.done = 1;
                q.push_back(e);
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = idle_ent();
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Compare at every falling edge; also advance the read-bus pattern
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2/R5", "ale", {31'd0, bus_ale}, {31'd0, cur.ale});
            chk("R3/R4/R6/R12", "rd_n", {31'd0, bus_rd_n}, {31'd0, cur.rd_n});
            chk("R3/R4/R6/R12", "wr_n", {31'd0, bus_wr_n}, {31'd0, cur.wr_n});
            chk("R8/R9", "ad_oe", {31'd0, bus_ad_oe}, {31'd0, cur.oe});
            chk("R10", "stall", {31'd0, req_stall}, {31'd0, cur.stall});
            chk("R7", "done", {31'd0, rsp_done}, {31'd0, cur.done});
            chk("R2", "addr_hi", {24'd0, bus_addr_hi}, {24'd0, exp_hi});
            if (cur.oe) chk("R2/R5/R8", "ad_out", {24'd0, bus_ad_out}, {24'd0, cur.ad});
            if (cur.done && !cur.wr) chk("R7", "rdata", {24'd0, rsp_rdata}, {24'd0, exp_rd});
            chk("R11", "ad_level", {24'd0, bus_ad_level}, {24'd0, cur.oe ? cur.ad : exp_keep});
            chk("R11", "keep_on", {31'd0, bus_keep_on}, {31'd0, cfg_keep_en && !cur.oe});
        end
        bus_ad_in <= {bus_ad_in[6:0], bus_ad_in[7] ^ bus_ad_in[5] ^ bus_ad_in[4] ^ bus_ad_in[3]};
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL R10 watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (req_stall) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (req_stall);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "ale in reset", {31'd0, bus_ale}, 32'd0);
        chk("R1", "rd_n in reset", {31'd0, bus_rd_n}, 32'd1);
        chk("R1", "wr_n in reset", {31'd0, bus_wr_n}, 32'd1);
        chk("R1", "oe in reset", {31'd0, bus_ad_oe}, 32'd0);
        chk("R1", "stall in reset", {31'd0, req_stall}, 32'd0);
        chk("R1", "done in reset", {31'd0, rsp_done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4 R5 R6: every wait code in both sectors, boundary 4
        for (int c = 0; c < 4; c++) begin
            cfg_wait_lower = c[1:0];
            cfg_wait_upper = 2'(3 - c);
            issue(1'b1, 16'h2311 + 16'(c), 8'hA0 + 8'(c));
            wait_idle();
            issue(1'b0, 16'h2A40 + 16'(c), 8'h00);
            wait_idle();
            issue(1'b1, 16'hC377 + 16'(c), 8'h3C + 8'(c));
            wait_idle();
            issue(1'b0, 16'hF101 + 16'(c), 8'h00);
            wait_idle();
        end

        // R6: boundary 0 sends everything upper, boundary 7 splits at top bits 7
        cfg_boundary = 3'd0; cfg_wait_lower = 2'b10; cfg_wait_upper = 2'b00;
        issue(1'b0, 16'h0012, 8'h00); wait_idle();
        cfg_boundary = 3'd7; cfg_wait_lower = 2'b11; cfg_wait_upper = 2'b01;
        issue(1'b1, 16'hC0AB, 8'h99); wait_idle();
        issue(1'b0, 16'hE0CD, 8'h00); wait_idle();

        // R11: keeper disabled then re-enabled
        cfg_keep_en = 1'b0;
        issue(1'b1, 16'h1234, 8'h6E); wait_idle();
        repeat (3) @(negedge clk);
        cfg_keep_en = 1'b1;
        issue(1'b0, 16'h5678, 8'h00); wait_idle();
        repeat (3) @(negedge clk);

        // R10: valid held high across busy periods; only idle cycles accept
        cfg_boundary = 3'd4; cfg_wait_lower = 2'b01; cfg_wait_upper = 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h9F0E; req_wdata = 8'h00;
        repeat (25) @(negedge clk);
        req_write = 1'b1; req_addr = 16'h1E0F; req_wdata = 8'hD2;
        repeat (25) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R12: configuration rewritten during a transfer
        cfg_wait_lower = 2'b00;
        issue(1'b1, 16'h0155, 8'h47);
        cfg_wait_lower = 2'b10; cfg_boundary = 3'd0;
        wait_idle();
        cfg_boundary = 3'd4; cfg_wait_lower = 2'b11;
        issue(1'b0, 16'h0266, 8'h00);
        cfg_wait_lower = 2'b00;
        wait_idle();

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule